// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides a 32-bit or 16-bit integer dividend by a 16-bit divisor. It returns a 16-bit quotient and a 16-bit remainder on separate ports. Two mode inputs select the operation: one chooses signed or unsigned arithmetic, the other chooses a double-width dividend (a high word and a low word) or a single-width dividend (the low word alone). Between them they give four modes: 32/16 and 16/16, each signed or unsigned.

The divider works on magnitudes with one shift-subtract step per divisor bit, then puts the signs back. A pulse on `start` while the block is idle captures the operands. The block stays busy for exactly 16 iteration cycles in every mode and then pulses `done`. The results and two flags, divide-by-zero and quotient overflow, stay on the outputs until the next operation finishes.

Top module: `iter_divider`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `quot`, `rem`, `div_zero` and `ovf` are all zero.
- R2: A `start` sampled high while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, 16 clock edges after the capturing edge, and `busy` is low in that cycle. The latency is the same for 32/16 and 16/16 operations.
- R3: A `start` sampled while `busy` is high is ignored: the running operation keeps its operands and finishes on its original schedule, and no second operation follows.
- R4: With `is_signed`=0 and `wide`=1, the dividend is {`dvd_hi`,`dvd_lo`} taken as unsigned, and the quotient and remainder are the unsigned floor quotient and remainder.
- R5: With `is_signed`=0 and `wide`=0, the dividend is `dvd_lo` zero-extended, and `dvd_hi` has no effect on any output.
- R6: With `is_signed`=1, the operands are two's complement, the quotient truncates toward zero, and the remainder has the sign of the dividend (or is zero).
- R7: With `is_signed`=1 and `wide`=0, the dividend is `dvd_lo` sign-extended, and `dvd_hi` has no effect on any output.
- R8: With a nonzero divisor, `ovf` is 1 exactly when the true quotient falls outside 0..65535 (unsigned) or -32768..32767 (signed). `quot` and `rem` are then unspecified.
- R9: A zero divisor gives `div_zero`=1, `ovf`=0, `quot`=16'hFFFF and `rem`=0, with the same latency as any other operation.
- R10: `quot`, `rem`, `ovf` and `div_zero` change only in the cycle in which `done` is high, and they hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| wide | input | 1 | 1 = 32-bit dividend {dvd_hi,dvd_lo}, 0 = 16-bit dividend dvd_lo |
| dvd_hi | input | 16 | Upper dividend word (used only when wide=1) |
| dvd_lo | input | 16 | Lower dividend word |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| quot | output | 16 | Quotient |
| rem | output | 16 | Remainder |
| div_zero | output | 1 | Last operation had a zero divisor |
| ovf | output | 1 | Last operation's quotient did not fit in 16 bits |

## Verification
The hardest cases to reach are quotients whose magnitude sits exactly at the signed boundary. A magnitude of 32768 is legal when the result is negative and an overflow when it is positive. The stimulus reaches both sides with wide signed dividends of -32768 and +32768 divided by one, and with the 16-bit case -32768 / -1. A second situation is a `start` pulse, with different operands, arriving in the middle of an operation. The bench raises it on the third iteration cycle, then checks that `done` still comes on the original edge, carries the first operation's results, and is not followed by a second `done`.

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic         wide,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         div_zero,
  output logic         ovf
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  // operand capture: extend, then take magnitudes
  logic [2*W-1:0] ext;
  logic           a_neg, b_neg;
  logic [2*W-1:0] a_mag;
  logic [W-1:0]   b_mag;

  assign ext   = wide ? {dvd_hi, dvd_lo} : {{W{is_signed & dvd_lo[W-1]}}, dvd_lo};
  assign a_neg = is_signed & ext[2*W-1];
  assign a_mag = a_neg ? -ext : ext;
  assign b_neg = is_signed & divisor[W-1];
  assign b_mag = b_neg ? -divisor : divisor;

  logic [CW-1:0] cnt;
  logic [W-1:0]  prem, qacc, bm;
  logic          q_neg, r_neg, sgn_r, dz_r, povf_r;

  // one restoring step
  logic [W:0]   sh, diff;
  logic         ge;
  logic [W-1:0] nprem, nq;
  logic         sov;

  assign sh    = {prem, qacc[W-1]};
  assign diff  = sh - {1'b0, bm};
  assign ge    = sh >= {1'b0, bm};
  assign nprem = ge ? diff[W-1:0] : sh[W-1:0];
  assign nq    = {qacc[W-2:0], ge};
  assign sov   = sgn_r & (q_neg ? (nq > MIN_NEG) : nq[W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      prem     <= '0;
      qacc     <= '0;
      bm       <= '0;
      q_neg    <= 1'b0;
      r_neg    <= 1'b0;
      sgn_r    <= 1'b0;
      dz_r     <= 1'b0;
      povf_r   <= 1'b0;
      quot     <= '0;
      rem      <= '0;
      div_zero <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          prem   <= a_mag[2*W-1:W];
          qacc   <= a_mag[W-1:0];
          bm     <= b_mag;
          q_neg  <= a_neg ^ b_neg;
          r_neg  <= a_neg;
          sgn_r  <= is_signed;
          dz_r   <= (divisor == '0);
          povf_r <= (a_mag[2*W-1:W] >= b_mag);
        end
      end else begin
        prem <= nprem;
        qacc <= nq;
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          div_zero <= dz_r;
          ovf      <= !dz_r && (povf_r || sov);
          quot     <= dz_r ? '1 : (q_neg ? -nq : nq);
          rem      <= dz_r ? '0 : (r_neg ? -nprem : nprem);
        end
      end
    end
  end

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  p_done_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_end_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));
  p_zero_not_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> !ovf);
  p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quot) && $stable(rem) && $stable(ovf) && $stable(div_zero)));

endmodule

// File: tb/sim_iter_divider.sv
`timescale 1ns/1ps
module sim_iter_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, is_signed = 1'b0, wide = 1'b0;
  logic [15:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic        busy, done, div_zero, ovf;
  logic [15:0] quot, rem;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  iter_divider u0 (.clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .wide(wide), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .busy(busy), .done(done), .quot(quot), .rem(rem), .div_zero(div_zero), .ovf(ovf));

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(bit s, bit w, logic [15:0] hi, logic [15:0] lo, logic [15:0] d,
                       output logic [15:0] eq, output logic [15:0] er,
                       output bit eov, output bit edz);
    longint a, b, q, r;
    if (w) a = s ? longint'($signed({hi, lo})) : longint'({hi, lo});
    else   a = s ? longint'($signed(lo)) : longint'(lo);
    b = s ? longint'($signed(d)) : longint'(d);
    edz = (b == 0);
    if (edz) begin
      eq = 16'hFFFF; er = 16'h0000; eov = 0;
    end else begin
      q = a / b;
      r = a % b;
      eov = s ? (q < -32768 || q > 32767) : (q > 65535);
      eq = q[15:0];
      er = r[15:0];
    end
  endtask

  task automatic drive(bit s, bit w, logic [15:0] hi, logic [15:0] lo, logic [15:0] d);
    is_signed = s; wide = w; dvd_hi = hi; dvd_lo = lo; divisor = d;
  endtask

  task automatic check_result(string tag, bit s, bit w, logic [15:0] hi, logic [15:0] lo,
                              logic [15:0] d);
    logic [15:0] eq, er;
    bit eov, edz;
    model(s, w, hi, lo, d, eq, er, eov, edz);
    check({tag, " div_zero (R9)"}, div_zero, edz);
    check({tag, " ovf (R8)"}, ovf, eov);
    if (!eov) begin
      check({tag, " quot"}, quot, eq);
      check({tag, " rem"}, rem, er);
    end
  endtask

  task automatic run_div(string tag, bit s, bit w, logic [15:0] hi, logic [15:0] lo,
                         logic [15:0] d);
    bit early = 0;
    @(negedge clk);
    drive(s, w, hi, lo, d);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 1; i <= 16; i++) begin
      @(posedge clk); #1;
      if (i < 16 && (done || !busy)) early = 1;
    end
    check({tag, " R2 no early done"}, early, 0);
    check({tag, " R2 done at 16"}, done, 1);
    check({tag, " R2 idle at done"}, busy, 0);
    check_result(tag, s, w, hi, lo, d);
  endtask

  task automatic t_reset_r1;
    #1;
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 quot", quot, 0); check("R1 rem", rem, 0);
    check("R1 flags", {div_zero, ovf}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {busy, done, div_zero, ovf, quot, rem}, 0);
  endtask

  task automatic t_unsigned_wide_r4;
    run_div("R4 a", 0, 1, 16'h0001, 16'h2345, 16'h0100);
    run_div("R4 b", 0, 1, 16'hFFFE, 16'hFFFF, 16'hFFFF);
    run_div("R4 c", 0, 1, 16'h0000, 16'h0007, 16'h0009);
  endtask

  task automatic t_unsigned_narrow_r5;
    run_div("R5 a", 0, 0, 16'hDEAD, 16'h1234, 16'h0011);
    run_div("R5 b", 0, 0, 16'hFFFF, 16'hFFFF, 16'h0001);
  endtask

  task automatic t_signed_wide_r6;
    run_div("R6 a", 1, 1, 16'hFFFE, 16'h7960, 16'h0007);
    run_div("R6 b", 1, 1, 16'h0001, 16'h86A0, 16'hFFF9);
    run_div("R6 c", 1, 1, 16'hFFFE, 16'h7960, 16'hFFF9);
    run_div("R6 min", 1, 1, 16'hFFFF, 16'h8000, 16'h0001);
  endtask

  task automatic t_signed_narrow_r7;
    run_div("R7 a", 1, 0, 16'h1234, 16'hFFF9, 16'h0002);
    run_div("R7 b", 1, 0, 16'h0000, 16'h8001, 16'h0100);
  endtask

  task automatic t_overflow_r8;
    run_div("R8 unsigned", 0, 1, 16'h0005, 16'h0000, 16'h0005);
    run_div("R8 pos32768", 1, 1, 16'h0000, 16'h8000, 16'h0001);
    run_div("R8 min/-1", 1, 0, 16'h0000, 16'h8000, 16'hFFFF);
    run_div("R8 big signed", 1, 1, 16'h4000, 16'h0000, 16'h0002);
  endtask

  task automatic t_div_zero_r9;
    run_div("R9 zero", 0, 1, 16'h1234, 16'h5678, 16'h0000);
    run_div("R9 zero s", 1, 0, 16'h0000, 16'h8000, 16'h0000);
  endtask

  task automatic t_start_ignored_r3;
    bit early = 0;
    @(negedge clk);
    drive(0, 1, 16'h0003, 16'h0000, 16'h1000);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 1; i <= 16; i++) begin
      @(posedge clk); #1;
      if (i == 3) begin drive(1, 0, 16'h0000, 16'hFFF0, 16'h0003); start = 1'b1; end
      if (i == 4) start = 1'b0;
      if (i < 16 && (done || !busy)) early = 1;
    end
    check("R3 schedule kept", early, 0);
    check("R3 done at 16", done, 1);
    check_result("R3 first operands", 0, 1, 16'h0003, 16'h0000, 16'h1000);
    @(posedge clk); #1;
    check("R3 no second op", {busy, done}, 0);
  endtask

  task automatic t_hold_r10;
    logic [15:0] q0, r0;
    run_div("R10 base", 0, 0, 16'h0000, 16'h0064, 16'h0007);
    q0 = quot; r0 = rem;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      drive(1, 1, 16'(i * 77), 16'(i * 301), 16'(i));
    end
    @(posedge clk); #1;
    check("R10 quot held", quot, q0);
    check("R10 rem held", rem, r0);
    check("R10 no done", done, 0);
  endtask

  initial begin
    t_reset_r1();
    t_unsigned_wide_r4();
    t_unsigned_narrow_r5();
    t_signed_wide_r6();
    t_signed_narrow_r7();
    t_overflow_r8();
    t_div_zero_r9();
    t_start_ignored_r3();
    t_hold_r10();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule